// File: doc/BRIEF.md
# I2C DAC Register Target

This block is the serial-bus slave end of a single-channel 12-bit digital-to-analog converter whose setting can be kept in a register that survives power loss. It oversamples the clock and data lines of a two-wire I2C bus with the system clock and recognises bus start and stop conditions. It answers its own 7-bit address and decodes three write commands of two lengths. A fast two-byte form and a DAC-only three-byte form change only the working register. A three-byte store form also copies the code and the power-down selection into the persistent register.

The working register drives the 12-bit code and the 2-bit power-down outputs. A store starts a busy window that lasts a fixed number of system clocks. A master can read a status byte, the working code and the stored code. A power-on reset puts a parameter value into the persistent register. A normal reset reloads the working register from the persistent one, so the last stored setting appears again at once.

Top module: `i2cdac_target`

## Requirements
- R1: The block answers the 7-bit address formed by the bits 1,1,0,0,0,0 followed by the `a0` pin. The address byte on the bus carries the address in bits 7..1 and read/write in bit 0. For any other address the block never pulls SDA low, and it ignores all bytes until the next start.
- R2: Fast write: the first byte after the address has bits 7..6 = 00. Its bits 5..4 are the power-down bits and its bits 3..0 are code bits 11..8. The second byte holds code bits 7..0. Both outputs update and the persistent register is left unchanged.
- R3: DAC-only write: the command byte has bits 7..5 = 010 and carries the power-down bits in bits 2..1. The next byte is code bits 11..4 and the upper nibble of the byte after it is code bits 3..0. The low nibble is ignored and the persistent register is left unchanged.
- R4: Store write: the command byte has bits 7..5 = 011 and uses the R3 layout. It updates both the working register and the persistent register. It then holds `busy` high for exactly PERSIST_CYCLES system clocks.
- R5: While `busy` is high, a store write changes neither register. Fast and DAC-only writes still take effect.
- R6: After power-on reset the persistent register holds PERSIST_INIT_CODE and PERSIST_INIT_PD. Every reset loads the working register from the persistent register and clears `busy`.
- R7: The block acknowledges its address and every write byte by pulling SDA low for the ninth clock of that byte.
- R8: A read returns a status byte (bit 7 = busy, bits 2..1 = power-down bits, other bits 0). Then come the working code and the stored code, each as two bytes: code bits 11..4, then code bits 3..0 followed by four zeros. After a master NACK the block releases SDA.
- R9: Inside one write transfer, the byte after a complete command is taken as a new command byte.
- R10: A command byte with bit 7 = 1 occupies three bytes and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; reloads working register |
| por_n | input | 1 | Synchronous active-low power-on reset of the persistent register |
| a0 | input | 1 | Lowest address bit |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_pull | output | 1 | High to pull the data line low (open drain) |
| dac_code | output | 12 | Current converter code |
| dac_pd | output | 2 | Current power-down selection |
| busy | output | 1 | Persistent store in progress |

## Verification
A command commit and a running busy window can act on the register stage in the same cycle. One must be taken and the other dropped, depending on the command type. The bench provokes this by sending a second store and then a fast write while the first store's window is still open. The output code must stay put for the store and follow the fast write. A later readback must still show the first stored code, and the busy-high cycle count is compared with the parameter.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;
    localparam int CODE_W   = 12;
    localparam int PD_W     = 2;
    localparam int BYTE_W   = 8;
    localparam int RD_BYTES = 5;
    localparam int FRAME_W  = RD_BYTES * BYTE_W;
    localparam logic [5:0] ADDR_FIXED = 6'b110000;

    typedef enum logic [2:0] {
        LK_IDLE = 3'd0,
        LK_ADDR = 3'd1,
        LK_WR   = 3'd2,
        LK_RD   = 3'd3,
        LK_IGN  = 3'd4
    } link_st_e;

    typedef struct packed {
        logic [1:0] meta;   // bit1 = scl, bit0 = sda
        logic [1:0] now;
        logic [1:0] prev;
    } sync_s;

    typedef struct packed {
        link_st_e          st;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] hi;
        logic [1:0]        widx;
        logic              rw;
        logic              nack;
        logic [2:0]        tidx;
        logic [BYTE_W-1:0] txbyte;
        logic              oe;
        logic              wr_valid;
        logic              wr_persist;
        logic [CODE_W-1:0] wr_code;
        logic [PD_W-1:0]   wr_pd;
    } link_s;
endpackage

// File: rtl/i2cdac_sync.sv
module i2cdac_sync
    import i2cdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    sync_s sy_q, sy_d;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = {scl, sda};
        sy_d.now  = sy_q.meta;
        sy_d.prev = sy_q.now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    assign sda_lvl   = sy_q.now[0];
    assign scl_rise  = sy_q.now[1] & ~sy_q.prev[1];
    assign scl_fall  = ~sy_q.now[1] & sy_q.prev[1];
    assign bus_start = sy_q.now[1] & sy_q.prev[1] & sy_q.prev[0] & ~sy_q.now[0];
    assign bus_stop  = sy_q.now[1] & sy_q.prev[1] & ~sy_q.prev[0] & sy_q.now[0];
endmodule

// File: rtl/i2cdac_link.sv
module i2cdac_link
    import i2cdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               a0,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  logic [FRAME_W-1:0] rd_frame,
    output logic               sda_pull,
    output logic               wr_valid,
    output logic               wr_persist,
    output logic [CODE_W-1:0]  wr_code,
    output logic [PD_W-1:0]    wr_pd
);
    link_s q, d;
    logic [2:0]        nxt_idx;
    logic [BYTE_W-1:0] nxt_byte;
    logic [2:0]        bsel;

    always_comb begin
        if (q.st == LK_ADDR || q.tidx == 3'(RD_BYTES - 1)) nxt_idx = 3'd0;
        else                                               nxt_idx = q.tidx + 3'd1;
        nxt_byte = rd_frame[(RD_BYTES - 1 - int'(nxt_idx)) * BYTE_W +: BYTE_W];
        bsel     = 3'(4'd7 - q.bitcnt);

        d          = q;
        d.wr_valid = 1'b0;
        if (bus_start) begin
            d.st     = LK_ADDR;
            d.bitcnt = '0;
            d.widx   = '0;
            d.oe     = 1'b0;
        end else if (bus_stop) begin
            d.st = LK_IDLE;
            d.oe = 1'b0;
        end else if (q.st == LK_ADDR || q.st == LK_WR || q.st == LK_RD) begin
            if (scl_rise) begin
                if (q.bitcnt < 4'd8) begin
                    d.shreg  = {q.shreg[BYTE_W-2:0], sda_lvl};
                    d.bitcnt = q.bitcnt + 4'd1;
                end else if (q.bitcnt == 4'd9) begin
                    d.nack = sda_lvl;
                end
            end else if (scl_fall) begin
                if (q.bitcnt == 4'd8) begin
                    d.bitcnt = 4'd9;
                    if (q.st == LK_ADDR) begin
                        if (q.shreg[7:1] == {ADDR_FIXED, a0}) begin
                            d.oe = 1'b1;
                            d.rw = q.shreg[0];
                        end else begin
                            d.st = LK_IGN;
                        end
                    end else if (q.st == LK_WR) begin
                        d.oe = 1'b1;
                        if (q.widx == 2'd0) begin
                            d.cmd  = q.shreg;
                            d.widx = 2'd1;
                        end else if (q.widx == 2'd1) begin
                            if (q.cmd[7:6] == 2'b00) begin
                                d.wr_valid   = 1'b1;
                                d.wr_persist = 1'b0;
                                d.wr_code    = {q.cmd[3:0], q.shreg};
                                d.wr_pd      = q.cmd[5:4];
                                d.widx       = 2'd0;
                            end else begin
                                d.hi   = q.shreg;
                                d.widx = 2'd2;
                            end
                        end else begin
                            d.widx = 2'd0;
                            if (!q.cmd[7]) begin
                                d.wr_valid   = 1'b1;
                                d.wr_persist = q.cmd[5];
                                d.wr_code    = {q.hi, q.shreg[7:4]};
                                d.wr_pd      = q.cmd[2:1];
                            end
                        end
                    end else begin
                        d.oe = 1'b0;        // master owns the acknowledge slot
                    end
                end else if (q.bitcnt == 4'd9) begin
                    d.bitcnt = '0;
                    d.oe     = 1'b0;
                    if (q.st == LK_ADDR) begin
                        if (q.rw) begin
                            d.st     = LK_RD;
                            d.tidx   = nxt_idx;
                            d.txbyte = nxt_byte;
                            d.oe     = ~nxt_byte[7];
                        end else begin
                            d.st   = LK_WR;
                            d.widx = 2'd0;
                        end
                    end else if (q.st == LK_RD) begin
                        if (q.nack) begin
                            d.st = LK_IGN;
                        end else begin
                            d.tidx   = nxt_idx;
                            d.txbyte = nxt_byte;
                            d.oe     = ~nxt_byte[7];
                        end
                    end
                end else if (q.st == LK_RD) begin
                    d.oe = ~q.txbyte[bsel];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pull   = q.oe;
    assign wr_valid   = q.wr_valid;
    assign wr_persist = q.wr_persist;
    assign wr_code    = q.wr_code;
    assign wr_pd      = q.wr_pd;

    assert_pull_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall || bus_start || bus_stop));

    assert_no_pull_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LK_IGN) |-> !q.oe);
endmodule

// File: rtl/i2cdac_regs.sv
module i2cdac_regs
    import i2cdac_pkg::*;
#(
    parameter int               PERSIST_CYCLES    = 2000,
    parameter logic [CODE_W-1:0] PERSIST_INIT_CODE = 12'h800,
    parameter logic [PD_W-1:0]   PERSIST_INIT_PD   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_valid,
    input  logic              wr_persist,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [PD_W-1:0]   wr_pd,
    output logic [CODE_W-1:0] dac_code,
    output logic [PD_W-1:0]   dac_pd,
    output logic              busy,
    output logic [CODE_W-1:0] nv_code
);
    localparam int CNT_W = $clog2(PERSIST_CYCLES + 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PD_W-1:0]   pd;
        logic [CNT_W-1:0]  cnt;
    } work_s;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PD_W-1:0]   pd;
    } nv_s;

    work_s wq, wd;
    nv_s   nq, nd;
    logic  take;

    assign busy = (wq.cnt != '0);

    always_comb begin
        wd   = wq;
        nd   = nq;
        take = wr_valid && !(wr_persist && busy);
        if (busy) wd.cnt = wq.cnt - CNT_W'(1);
        if (take) begin
            wd.code = wr_code;
            wd.pd   = wr_pd;
            if (wr_persist) begin
                nd.code = wr_code;
                nd.pd   = wr_pd;
                wd.cnt  = CNT_W'(PERSIST_CYCLES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) nq <= '{code: PERSIST_INIT_CODE, pd: PERSIST_INIT_PD};
        else        nq <= nd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wq <= '{code: nq.code, pd: nq.pd, cnt: '0};
        else        wq <= wd;
    end

    assign dac_code = wq.code;
    assign dac_pd   = wq.pd;
    assign nv_code  = nq.code;

    assert_nv_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        busy |=> ($stable(nq.code) && $stable(nq.pd)));

    assert_code_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wq.code) |-> $past(wr_valid));

    assert_busy_from_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_valid && wr_persist));
endmodule

// File: rtl/i2cdac_target.sv
module i2cdac_target
    import i2cdac_pkg::*;
#(
    parameter int                PERSIST_CYCLES    = 2000,
    parameter logic [CODE_W-1:0] PERSIST_INIT_CODE = 12'h800,
    parameter logic [PD_W-1:0]   PERSIST_INIT_PD   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              a0,
    input  logic              scl,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [CODE_W-1:0] dac_code,
    output logic [PD_W-1:0]   dac_pd,
    output logic              busy
);
    logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic wr_valid, wr_persist;
    logic [CODE_W-1:0] wr_code, nv_code;
    logic [PD_W-1:0]   wr_pd;
    logic [FRAME_W-1:0] rd_frame;

    assign rd_frame = {busy, 4'b0000, dac_pd, 1'b0,
                       dac_code[11:4], dac_code[3:0], 4'b0000,
                       nv_code[11:4],  nv_code[3:0],  4'b0000};

    i2cdac_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2cdac_link u_link (
        .clk(clk), .rst_n(rst_n), .a0(a0), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .rd_frame(rd_frame),
        .sda_pull(sda_pull), .wr_valid(wr_valid), .wr_persist(wr_persist),
        .wr_code(wr_code), .wr_pd(wr_pd)
    );

    i2cdac_regs #(
        .PERSIST_CYCLES(PERSIST_CYCLES),
        .PERSIST_INIT_CODE(PERSIST_INIT_CODE),
        .PERSIST_INIT_PD(PERSIST_INIT_PD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_valid(wr_valid), .wr_persist(wr_persist),
        .wr_code(wr_code), .wr_pd(wr_pd),
        .dac_code(dac_code), .dac_pd(dac_pd), .busy(busy), .nv_code(nv_code)
    );
endmodule

// File: tb/i2cdac_target_test.sv
module i2cdac_target_test;
    localparam int Q  = 10;
    localparam int PC = 6000;

    // {nbytes[3:0], b0, b1, b2, code[11:0], pd[1:0]}
    localparam logic [41:0] VEC [6] = '{
        {4'd2, 8'h0A, 8'hBC, 8'h00, 12'hABC, 2'd0},
        {4'd2, 8'h25, 8'h5A, 8'h00, 12'h55A, 2'd2},
        {4'd3, 8'h40, 8'h12, 8'h3F, 12'h123, 2'd0},
        {4'd3, 8'h46, 8'hFF, 8'hF0, 12'hFFF, 2'd3},
        {4'd3, 8'h42, 8'h00, 8'h0F, 12'h000, 2'd1},
        {4'd3, 8'h80, 8'h77, 8'h70, 12'h000, 2'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_n = 1'b0;
    logic a0 = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, busy;
    logic [11:0] dac_code;
    logic [1:0]  dac_pd;
    logic sda_bus;
    int checks = 0;
    int fails = 0;
    int busy_cycles = 0;
    bit pulled_seen = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    i2cdac_target #(.PERSIST_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .a0(a0), .scl(scl_m),
        .sda_in(sda_bus), .sda_pull(sda_pull), .dac_code(dac_code),
        .dac_pd(dac_pd), .busy(busy)
    );

    always @(negedge clk) begin
        if (busy) busy_cycles = busy_cycles + 1;
        if (sda_pull) pulled_seen = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2 * Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_bus; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = nack; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic write3(input string tag, input logic [7:0] b0, b1, b2);
        logic ack;
        bus_start();
        send(8'hC0, ack); chk({tag, " R7 addr ack"}, ack, 1);
        send(b0, ack);    chk({tag, " R7 ack"}, ack, 1);
        send(b1, ack);    chk({tag, " R7 ack"}, ack, 1);
        send(b2, ack);    chk({tag, " R7 ack"}, ack, 1);
        bus_stop();
        wq(Q);
    endtask

    task automatic write2(input string tag, input logic [7:0] b0, b1);
        logic ack;
        bus_start();
        send(8'hC0, ack); chk({tag, " R7 addr ack"}, ack, 1);
        send(b0, ack);    chk({tag, " R7 ack"}, ack, 1);
        send(b1, ack);    chk({tag, " R7 ack"}, ack, 1);
        bus_stop();
        wq(Q);
    endtask

    task automatic do_resets(input bit power);
        rst_n = 1'b0;
        if (power) por_n = 1'b0;
        wq(4);
        por_n = 1'b1;
        wq(3);
        rst_n = 1'b1;
        wq(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements) act=timeout exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        int guard;
        do_resets(1'b1);

        // R6: power-on state
        chk("R6 por code", dac_code, 12'h800);
        chk("R6 por pd", dac_pd, 0);
        chk("R6 busy clear", busy, 0);
        chk("R7 idle no pull", sda_pull, 0);

        // table walk: R2 fast, R3 DAC-only, R10 reserved
        for (int i = 0; i < 6; i++) begin
            logic [41:0] v;
            string tag;
            v = VEC[i];
            tag = (v[41:38] == 4'd2) ? "R2" : (v[37] ? "R10" : "R3");
            if (v[41:38] == 4'd2) write2(tag, v[37:30], v[29:22]);
            else                  write3(tag, v[37:30], v[29:22], v[21:14]);
            chk({tag, " code"}, dac_code, int'(v[13:2]));
            chk({tag, " pd"}, dac_pd, int'(v[1:0]));
        end

        // R1: foreign address is not acknowledged and bytes are ignored
        pulled_seen = 1'b0;
        bus_start();
        send(8'hC2, ack); chk("R1 foreign addr nack", ack, 0);
        send(8'h0F, ack);
        send(8'hFF, ack);
        bus_stop();
        wq(Q);
        chk("R1 no pull seen", pulled_seen, 0);
        chk("R1 code unchanged", dac_code, 12'h000);

        // R1: a0 pin selects the address
        a0 = 1'b1;
        bus_start();
        send(8'hC2, ack); chk("R1 a0 addr ack", ack, 1);
        send(8'h07, ack);
        send(8'h89, ack);
        bus_stop();
        wq(Q);
        a0 = 1'b0;
        chk("R1 a0 write code", dac_code, 12'h789);

        // R4: store write
        busy_cycles = 0;
        write3("R4", 8'h62, 8'h3A, 8'h5C);
        chk("R4 code", dac_code, 12'h3A5);
        chk("R4 pd", dac_pd, 1);
        chk("R4 busy high", busy, 1);

        // R5: store during busy ignored, fast write accepted
        write3("R5", 8'h60, 8'h11, 8'h10);
        chk("R5 store ignored", dac_code, 12'h3A5);
        write2("R5", 8'h01, 8'h23);
        chk("R5 fast during busy", dac_code, 12'h123);
        chk("R5 fast pd", dac_pd, 0);
        chk("R5 still busy", busy, 1);

        // R8: status shows busy
        bus_start();
        send(8'hC1, ack); chk("R8 read addr ack", ack, 1);
        recv(1'b1, rb);   chk("R8 status busy", rb, 8'h80);
        chk("R8 release after nack", sda_pull, 0);
        bus_stop();

        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk("R4 busy length", busy_cycles, PC);

        // R8: full readback; stored code shows the ignored store left it alone
        bus_start();
        send(8'hC1, ack); chk("R8 read addr ack", ack, 1);
        recv(1'b0, rb); chk("R8 status", rb, 8'h00);
        recv(1'b0, rb); chk("R8 code hi", rb, 8'h12);
        recv(1'b0, rb); chk("R8 code lo", rb, 8'h30);
        recv(1'b0, rb); chk("R5 stored hi", rb, 8'h3A);
        recv(1'b1, rb); chk("R5 stored lo", rb, 8'h50);
        chk("R8 release after nack", sda_pull, 0);
        bus_stop();
        wq(Q);

        // R9: two commands in one transfer
        bus_start();
        send(8'hC0, ack);
        send(8'h40, ack);
        send(8'h45, ack);
        send(8'h60, ack);
        chk("R9 first command applied", dac_code, 12'h456);
        send(8'h0F, ack); chk("R9 R7 ack second cmd", ack, 1);
        send(8'hED, ack);
        bus_stop();
        wq(Q);
        chk("R9 second command", dac_code, 12'hFED);
        chk("R9 pd", dac_pd, 0);

        // R6: plain reset reloads stored setting
        do_resets(1'b0);
        chk("R6 reload code", dac_code, 12'h3A5);
        chk("R6 reload pd", dac_pd, 1);
        chk("R6 busy clear", busy, 0);

        // R6: power-on reset restores parameter value
        do_resets(1'b1);
        chk("R6 por again code", dac_code, 12'h800);
        chk("R6 por again pd", dac_pd, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule